// File: doc/BRIEF.md
# Address Quadrant Context Selector

This block sits in front of a radix page-table walker and classifies each translation request before any memory is touched. From the two top bits of the effective address and the hypervisor-mode flag it picks the partition ID and the process ID that the walk must use. It decides whether the walk needs a process-scoped stage, a partition-scoped stage, or both. It also rejects address quadrants that a guest may not use.

When relocation is off in hypervisor mode, no walk is needed. The block forms the real address itself: it clears the top four address bits, applies a relocation offset for low addresses, and grants full permission. When a request cannot be completed, the block selects the interrupt class and prepares the fault-register values. A request cannot be completed when the quadrant is illegal, when the walker reports a storage fault, or when the access type is malformed.

Requests are accepted with a valid/ready handshake. The result is registered and presented one cycle later with its own valid/ready handshake toward the walker.

Top module: `quad_ctx_sel`

## Requirements
- R1: After reset `out_valid` is 0 and `req_ready` is 1.
- R2: A request accepted on a clock edge (`req_valid` and `req_ready` high) gives `out_valid` = 1 after that edge. `req_ready` equals `!out_valid || out_ready`. While `out_valid` is 1 and `out_ready` is 0, every result output holds its value.
- R3: In hypervisor mode with relocation on, the quadrant `ea[63:62]` selects the IDs as follows:
  - quadrant 0 gives partition 0 and PID = `pid_reg`;
  - quadrant 1 gives `part_reg` and `pid_reg`;
  - quadrant 2 gives `part_reg` and PID 0;
  - quadrant 3 gives partition 0 and PID 0.
- R4: In guest mode, quadrant 0 selects `part_reg` with `pid_reg`, and quadrant 3 selects `part_reg` with PID 0. Both set `o_walk` = 1.
- R5: In guest mode, quadrants 1 and 2 raise a segment interrupt.
  - For a fetch, `o_intr` = 1 (instruction segment) and `o_far_we` = 0.
  - For a load or store, `o_intr` = 2 (data segment), `o_far_we` = 1 and `o_far` = ea.
  - In both cases `o_walk` = 0.
- R6: Access type `req_kind` is encoded 0 = load, 1 = store, 2 = fetch. Relocation is `ir_en` for a fetch and `dr_en` for a load or store. `o_proc` (process-scoped stage needed) equals the relocation value whenever a walk is requested.
- R7: In hypervisor mode with relocation off, the block bypasses the walk: `o_bypass` = 1, `o_walk` = 0 and `o_perm` = 3'b111 (read, write, execute in bits 2, 1, 0). `o_raddr` is ea with bits 63:60 cleared, ORed with `reloc_off` only when ea bit 63 is 0.
- R8: When a walk is requested, `o_part` (partition-scoped stage needed) is 1 exactly when the selected partition ID is non-zero or guest mode is active. Guest mode with relocation off still walks, with `o_proc` = 0 and `o_part` = 1.
- R9: A storage fault reported with the request (`walk_flt` = 1) produces the following results:
  - For a fetch: `o_intr` = 3 and `o_errcode` = `walk_cause`.
  - For a load: `o_intr` = 4, `o_dsisr_we` = 1, `o_dsisr` = `walk_cause`, and `o_far` = ea with `o_far_we` = 1.
  - For a store: the same as a load, but `o_dsisr` = `walk_cause` with bit 25 (the is-store bit) set.
- R10: `req_kind` = 3 gives `o_intr` = 5 with `o_walk`, `o_bypass`, `o_far_we` and `o_dsisr_we` all 0.
- R11: When more than one condition applies, the malformed access type wins over a reported storage fault. A reported storage fault wins over an illegal guest quadrant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Request can be accepted |
| req_ea | input | EA_W | Effective address |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 illegal |
| hv_mode | input | 1 | Hypervisor mode flag |
| ir_en | input | 1 | Instruction relocation enable |
| dr_en | input | 1 | Data relocation enable |
| walk_flt | input | 1 | Storage fault reported for this request |
| walk_cause | input | CAUSE_W | Storage fault cause bits |
| part_reg | input | LPID_W | Partition ID register |
| pid_reg | input | PID_W | Process ID register |
| reloc_off | input | EA_W | Real-mode relocation offset |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Walker accepts result |
| o_lpid | output | LPID_W | Selected partition ID |
| o_pid | output | PID_W | Selected process ID |
| o_walk | output | 1 | Page walk required |
| o_proc | output | 1 | Process-scoped stage needed |
| o_part | output | 1 | Partition-scoped stage needed |
| o_bypass | output | 1 | Real address resolved directly |
| o_raddr | output | EA_W | Bypass real address |
| o_perm | output | 3 | Bypass permission {read, write, execute} |
| o_intr | output | 3 | Interrupt class: 0 none, 1 inst segment, 2 data segment, 3 inst storage, 4 data storage, 5 bad request |
| o_far_we | output | 1 | Load fault address register |
| o_far | output | EA_W | Fault address value |
| o_dsisr_we | output | 1 | Load data fault status register |
| o_dsisr | output | CAUSE_W | Data fault status value |
| o_errcode | output | CAUSE_W | Error code for instruction storage faults |

## Verification
All four quadrants are driven in hypervisor mode. This separates the two partition choices from the two process choices, because each quadrant is a distinct pairing. Guest-mode requests walk the legal quadrants and try both illegal ones: one as a fetch and one as a store. This shows that the fault address is loaded only for data accesses.

Real-mode addresses with the top bit clear and set show whether the offset is applied conditionally and whether the top nibble is cleared. Mixing fetch and load with opposite relocation flags shows which flag each access type uses. Storage faults on all three access types expose the store-bit merge. Combined faults check the priority order, and a stalled output with a competing request checks that results are held.

// File: rtl/quad_ctx_sel.sv
module quad_ctx_sel #(
  parameter int EA_W      = 64,
  parameter int LPID_W    = 12,
  parameter int PID_W     = 20,
  parameter int CAUSE_W   = 32,
  parameter int STORE_BIT = 25
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [EA_W-1:0]    req_ea,
  input  logic [1:0]         req_kind,
  input  logic               hv_mode,
  input  logic               ir_en,
  input  logic               dr_en,
  input  logic               walk_flt,
  input  logic [CAUSE_W-1:0] walk_cause,
  input  logic [LPID_W-1:0]  part_reg,
  input  logic [PID_W-1:0]   pid_reg,
  input  logic [EA_W-1:0]    reloc_off,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [LPID_W-1:0]  o_lpid,
  output logic [PID_W-1:0]   o_pid,
  output logic               o_walk,
  output logic               o_proc,
  output logic               o_part,
  output logic               o_bypass,
  output logic [EA_W-1:0]    o_raddr,
  output logic [2:0]         o_perm,
  output logic [2:0]         o_intr,
  output logic               o_far_we,
  output logic [EA_W-1:0]    o_far,
  output logic               o_dsisr_we,
  output logic [CAUSE_W-1:0] o_dsisr,
  output logic [CAUSE_W-1:0] o_errcode
);

  localparam logic [2:0] INT_NONE  = 3'd0;
  localparam logic [2:0] INT_ISEG  = 3'd1;
  localparam logic [2:0] INT_DSEG  = 3'd2;
  localparam logic [2:0] INT_ISTOR = 3'd3;
  localparam logic [2:0] INT_DSTOR = 3'd4;
  localparam logic [2:0] INT_BAD   = 3'd5;
  localparam logic [EA_W-1:0] LOW_MASK = {4'b0000, {(EA_W-4){1'b1}}};
  localparam logic [CAUSE_W-1:0] STORE_FLAG = CAUSE_W'(1) << STORE_BIT;

  logic [1:0] quad;
  logic is_fetch, is_store, is_bad, reloc, quad_ok;
  logic [LPID_W-1:0] sel_lpid;
  logic [PID_W-1:0]  sel_pid;
  logic [EA_W-1:0]   real_addr;
  logic accept;

  assign quad      = req_ea[EA_W-1 -: 2];
  assign is_fetch  = (req_kind == 2'd2);
  assign is_store  = (req_kind == 2'd1);
  assign is_bad    = (req_kind == 2'd3);
  assign reloc     = is_fetch ? ir_en : dr_en;
  assign real_addr = (req_ea & LOW_MASK) | (req_ea[EA_W-1] ? '0 : reloc_off);
  assign req_ready = !out_valid || out_ready;
  assign accept    = req_valid && req_ready;

  always_comb begin
    quad_ok  = 1'b1;
    sel_lpid = '0;
    sel_pid  = '0;
    if (hv_mode) begin
      case (quad)
        2'd0: sel_pid = pid_reg;
        2'd1: begin sel_lpid = part_reg; sel_pid = pid_reg; end
        2'd2: sel_lpid = part_reg;
        default: ;
      endcase
    end else begin
      case (quad)
        2'd0: begin sel_lpid = part_reg; sel_pid = pid_reg; end
        2'd3: sel_lpid = part_reg;
        default: quad_ok = 1'b0;
      endcase
    end
  end

  logic [LPID_W-1:0]  n_lpid;
  logic [PID_W-1:0]   n_pid;
  logic               n_walk, n_proc, n_part, n_bypass, n_far_we, n_dsisr_we;
  logic [EA_W-1:0]    n_raddr, n_far;
  logic [2:0]         n_perm, n_intr;
  logic [CAUSE_W-1:0] n_dsisr, n_errcode;

  always_comb begin
    n_lpid = '0; n_pid = '0;
    n_walk = 1'b0; n_proc = 1'b0; n_part = 1'b0; n_bypass = 1'b0;
    n_raddr = '0; n_perm = 3'b000; n_intr = INT_NONE;
    n_far_we = 1'b0; n_far = '0;
    n_dsisr_we = 1'b0; n_dsisr = '0; n_errcode = '0;
    if (is_bad) begin
      n_intr = INT_BAD;
    end else if (walk_flt) begin
      if (is_fetch) begin
        n_intr    = INT_ISTOR;
        n_errcode = walk_cause;
      end else begin
        n_intr     = INT_DSTOR;
        n_dsisr_we = 1'b1;
        n_dsisr    = walk_cause | (is_store ? STORE_FLAG : '0);
        n_far_we   = 1'b1;
        n_far      = req_ea;
      end
    end else if (hv_mode && !reloc) begin
      n_bypass = 1'b1;
      n_raddr  = real_addr;
      n_perm   = 3'b111;
    end else if (!quad_ok) begin
      if (is_fetch) begin
        n_intr = INT_ISEG;
      end else begin
        n_intr   = INT_DSEG;
        n_far_we = 1'b1;
        n_far    = req_ea;
      end
    end else begin
      n_walk = 1'b1;
      n_lpid = sel_lpid;
      n_pid  = sel_pid;
      n_proc = reloc;
      n_part = (sel_lpid != '0) || !hv_mode;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      o_lpid <= '0; o_pid <= '0;
      o_walk <= 1'b0; o_proc <= 1'b0; o_part <= 1'b0; o_bypass <= 1'b0;
      o_raddr <= '0; o_perm <= '0; o_intr <= INT_NONE;
      o_far_we <= 1'b0; o_far <= '0;
      o_dsisr_we <= 1'b0; o_dsisr <= '0; o_errcode <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      o_lpid <= n_lpid; o_pid <= n_pid;
      o_walk <= n_walk; o_proc <= n_proc; o_part <= n_part; o_bypass <= n_bypass;
      o_raddr <= n_raddr; o_perm <= n_perm; o_intr <= n_intr;
      o_far_we <= n_far_we; o_far <= n_far;
      o_dsisr_we <= n_dsisr_we; o_dsisr <= n_dsisr; o_errcode <= n_errcode;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/quad_ctx_sel_chk.sv
module quad_ctx_sel_chk #(
  parameter int EA_W   = 64,
  parameter int LPID_W = 12,
  parameter int PID_W  = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [LPID_W-1:0] o_lpid,
  input logic [PID_W-1:0]  o_pid,
  input logic              o_walk,
  input logic              o_bypass,
  input logic [EA_W-1:0]   o_raddr,
  input logic [2:0]        o_perm,
  input logic [2:0]        o_intr,
  input logic              o_far_we,
  input logic              o_dsisr_we
);

  // R2
  accept_gives_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> out_valid);

  // R2
  stall_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(o_raddr) && $stable(o_intr)
      && $stable(o_lpid) && $stable(o_pid) && $stable(o_walk));

  // R7
  bypass_full_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && o_bypass |-> o_perm == 3'b111 && !o_walk && o_intr == 3'd0);

  // R5
  iseg_no_far_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && o_intr == 3'd1 |-> !o_far_we && !o_walk);

  // R5
  dseg_far_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && o_intr == 3'd2 |-> o_far_we && !o_walk);

  // R9
  dstor_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && o_intr == 3'd4 |-> o_far_we && o_dsisr_we);

  // R10
  bad_req_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && o_intr == 3'd5 |-> !o_walk && !o_bypass && !o_far_we && !o_dsisr_we);

  // R11
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0({o_walk, o_bypass, o_intr != 3'd0}));

endmodule

bind quad_ctx_sel quad_ctx_sel_chk #(.EA_W(EA_W), .LPID_W(LPID_W), .PID_W(PID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .out_valid(out_valid), .out_ready(out_ready), .o_lpid(o_lpid), .o_pid(o_pid),
  .o_walk(o_walk), .o_bypass(o_bypass), .o_raddr(o_raddr), .o_perm(o_perm),
  .o_intr(o_intr), .o_far_we(o_far_we), .o_dsisr_we(o_dsisr_we)
);

// File: tb/quad_ctx_sel_tb.sv
module quad_ctx_sel_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, out_ready = 1'b1;
  logic [63:0] req_ea = '0;
  logic [1:0] req_kind = '0;
  logic hv_mode = 1'b0, ir_en = 1'b0, dr_en = 1'b0, walk_flt = 1'b0;
  logic [31:0] walk_cause = '0;
  logic [11:0] part_reg = 12'h2A5;
  logic [19:0] pid_reg = 20'h12345;
  logic [63:0] reloc_off = 64'h0000_0000_4000_0000;
  logic req_ready, out_valid;
  logic [11:0] o_lpid;
  logic [19:0] o_pid;
  logic o_walk, o_proc, o_part, o_bypass, o_far_we, o_dsisr_we;
  logic [63:0] o_raddr, o_far;
  logic [2:0] o_perm, o_intr;
  logic [31:0] o_dsisr, o_errcode;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  quad_ctx_sel u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_ea(req_ea), .req_kind(req_kind), .hv_mode(hv_mode), .ir_en(ir_en),
    .dr_en(dr_en), .walk_flt(walk_flt), .walk_cause(walk_cause),
    .part_reg(part_reg), .pid_reg(pid_reg), .reloc_off(reloc_off),
    .out_valid(out_valid), .out_ready(out_ready), .o_lpid(o_lpid), .o_pid(o_pid),
    .o_walk(o_walk), .o_proc(o_proc), .o_part(o_part), .o_bypass(o_bypass),
    .o_raddr(o_raddr), .o_perm(o_perm), .o_intr(o_intr), .o_far_we(o_far_we),
    .o_far(o_far), .o_dsisr_we(o_dsisr_we), .o_dsisr(o_dsisr), .o_errcode(o_errcode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic go(input logic [63:0] ea, input logic [1:0] kind, input logic hv,
                    input logic ir, input logic dr, input logic flt, input logic [31:0] cause);
    @(negedge clk);
    req_ea = ea; req_kind = kind; hv_mode = hv; ir_en = ir; dr_en = dr;
    walk_flt = flt; walk_cause = cause; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 valid after accept", 64'(out_valid), 64'd1);
  endtask

  task automatic t_reset;
    chk("R1 out_valid at reset", 64'(out_valid), 64'd0);
    chk("R1 req_ready at reset", 64'(req_ready), 64'd1);
  endtask

  task automatic t_hv_quads;
    go(64'h0000_1234_5678_9ABC, 2'd0, 1, 0, 1, 0, 0);
    chk("R3 q0 lpid", 64'(o_lpid), 64'h0); chk("R3 q0 pid", 64'(o_pid), 64'h12345);
    chk("R8 q0 part", 64'(o_part), 64'd0); chk("R6 q0 proc", 64'(o_proc), 64'd1);
    go(64'h4000_0000_0000_1000, 2'd0, 1, 0, 1, 0, 0);
    chk("R3 q1 lpid", 64'(o_lpid), 64'h2A5); chk("R3 q1 pid", 64'(o_pid), 64'h12345);
    chk("R8 q1 part", 64'(o_part), 64'd1);
    go(64'h8000_0000_0000_1000, 2'd1, 1, 0, 1, 0, 0);
    chk("R3 q2 lpid", 64'(o_lpid), 64'h2A5); chk("R3 q2 pid", 64'(o_pid), 64'h0);
    go(64'hC000_0000_0000_1000, 2'd0, 1, 0, 1, 0, 0);
    chk("R3 q3 lpid", 64'(o_lpid), 64'h0); chk("R3 q3 pid", 64'(o_pid), 64'h0);
    chk("R3 q3 walk", 64'(o_walk), 64'd1);
  endtask

  task automatic t_guest_quads;
    go(64'h0000_0000_0000_2000, 2'd0, 0, 0, 1, 0, 0);
    chk("R4 q0 lpid", 64'(o_lpid), 64'h2A5); chk("R4 q0 pid", 64'(o_pid), 64'h12345);
    chk("R4 q0 walk", 64'(o_walk), 64'd1); chk("R8 guest part", 64'(o_part), 64'd1);
    go(64'hC000_0000_0000_2000, 2'd2, 0, 1, 0, 0, 0);
    chk("R4 q3 lpid", 64'(o_lpid), 64'h2A5); chk("R4 q3 pid", 64'(o_pid), 64'h0);
    chk("R6 fetch uses ir", 64'(o_proc), 64'd1);
    go(64'h4000_0000_0000_3000, 2'd2, 0, 1, 1, 0, 0);
    chk("R5 q1 fetch intr", 64'(o_intr), 64'd1); chk("R5 q1 no far", 64'(o_far_we), 64'd0);
    chk("R5 q1 no walk", 64'(o_walk), 64'd0);
    go(64'h8000_0000_0000_3008, 2'd1, 0, 1, 1, 0, 0);
    chk("R5 q2 store intr", 64'(o_intr), 64'd2); chk("R5 q2 far_we", 64'(o_far_we), 64'd1);
    chk("R5 q2 far", o_far, 64'h8000_0000_0000_3008);
  endtask

  task automatic t_reloc_sel;
    go(64'h0000_0000_0000_5000, 2'd2, 1, 0, 1, 0, 0);
    chk("R6 fetch ir=0 bypass", 64'(o_bypass), 64'd1);
    go(64'h0000_0000_0000_5000, 2'd0, 1, 0, 1, 0, 0);
    chk("R6 load dr=1 walk", 64'(o_walk), 64'd1);
    go(64'h0000_0000_0000_5000, 2'd0, 0, 1, 0, 0, 0);
    chk("R8 guest real walk", 64'(o_walk), 64'd1);
    chk("R8 guest real proc", 64'(o_proc), 64'd0);
    chk("R8 guest real part", 64'(o_part), 64'd1);
  endtask

  task automatic t_real_mode;
    go(64'h3123_4567_89AB_C000, 2'd0, 1, 1, 0, 0, 0);
    chk("R7 low raddr", o_raddr, 64'h0123_4567_C9AB_C000);
    chk("R7 perm", 64'(o_perm), 64'h7); chk("R7 no walk", 64'(o_walk), 64'd0);
    go(64'hF000_0000_0010_0000, 2'd1, 1, 1, 0, 0, 0);
    chk("R7 high raddr", o_raddr, 64'h0000_0000_0010_0000);
    chk("R7 high bypass", 64'(o_bypass), 64'd1);
  endtask

  task automatic t_storage;
    go(64'h0000_0000_0000_7000, 2'd2, 1, 1, 1, 1, 32'h4000_0000);
    chk("R9 fetch intr", 64'(o_intr), 64'd3); chk("R9 fetch err", 64'(o_errcode), 64'h4000_0000);
    chk("R9 fetch no dsisr", 64'(o_dsisr_we), 64'd0);
    go(64'h0000_0000_0000_7010, 2'd0, 1, 1, 1, 1, 32'h4000_0000);
    chk("R9 load intr", 64'(o_intr), 64'd4); chk("R9 load dsisr", 64'(o_dsisr), 64'h4000_0000);
    chk("R9 load far", o_far, 64'h0000_0000_0000_7010);
    go(64'h0000_0000_0000_7020, 2'd1, 1, 1, 1, 1, 32'h0800_0000);
    chk("R9 store dsisr", 64'(o_dsisr), 64'h0A00_0000);
    chk("R9 store far_we", 64'(o_far_we), 64'd1);
  endtask

  task automatic t_bad_prio;
    go(64'h0000_0000_0000_9000, 2'd3, 1, 1, 1, 0, 0);
    chk("R10 intr", 64'(o_intr), 64'd5); chk("R10 no walk", 64'(o_walk), 64'd0);
    chk("R10 no far", 64'(o_far_we), 64'd0);
    go(64'h0000_0000_0000_9000, 2'd3, 1, 1, 1, 1, 32'h1);
    chk("R11 bad over fault", 64'(o_intr), 64'd5);
    go(64'h4000_0000_0000_9000, 2'd0, 0, 1, 1, 1, 32'h2);
    chk("R11 fault over quadrant", 64'(o_intr), 64'd4);
    chk("R11 dsisr", 64'(o_dsisr), 64'h2);
  endtask

  task automatic t_stall;
    out_ready = 1'b0;
    go(64'hC000_0000_0000_A000, 2'd0, 1, 0, 1, 0, 0);
    chk("R2 ready low when stalled", 64'(req_ready), 64'd0);
    req_ea = 64'h4000_0000_0000_B000; req_kind = 2'd0; req_valid = 1'b1;
    @(negedge clk);
    chk("R2 held lpid", 64'(o_lpid), 64'h0);
    chk("R2 held valid", 64'(out_valid), 64'd1);
    out_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 next result lpid", 64'(o_lpid), 64'h2A5);
    @(negedge clk);
    chk("R2 drains", 64'(out_valid), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_hv_quads;
    t_guest_quads;
    t_reloc_sel;
    t_real_mode;
    t_storage;
    t_bad_prio;
    t_stall;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule